// File: doc/BRIEF.md
# Entropy-Backed Random Word Register

This block holds one 32-bit word of random data for software, plus a two-bit status view. It fetches each word from an external entropy source over a level request and a one-cycle acknowledge. The acknowledge carries the 32-bit word and a flag that marks the word as produced in a compliance-approved mode.

Reading the data word while it is valid returns it and consumes it. The consumed word is dropped and a fresh fetch starts at once. While no word is held, the data output reads as zero and the fetch request stays raised. After reset no word is held and the first fetch is already requested.

Top module: `rnd_word_reg`

## Requirements
- R1: After reset, `rdata_o` is 0, `status_o` is 2'b00 and `ent_req_o` is 1.
- R2: When `ent_ack_i` is high while `ent_req_o` is high, the word on `ent_data_i` is stored. From the next cycle on, `status_o[0]` (valid) is 1, `rdata_o` shows the word and `ent_req_o` is 0.
- R3: `status_o[1]` (compliance flag) takes the value of `ent_fips_i` sampled together with the stored word.
- R4: A read strobe (`rd_i`) while valid leaves the word on `rdata_o` in that cycle. From the next cycle, `status_o` is 2'b00, `rdata_o` is 0 and `ent_req_o` is 1.
- R5: A read strobe while invalid changes nothing. `rdata_o` stays 0 and `ent_req_o` stays high as one continuous request, not a second one.
- R6: `ent_ack_i` while no request is pending is ignored, and the held word and flag are unchanged.
- R7: When an acknowledge arrives in the same cycle as a read strobe, the arriving word is stored as the new valid word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_i | input | 1 | Read strobe for the data word |
| rdata_o | output | 32 | Data word, zero while invalid |
| status_o | output | 2 | Bit 0 valid, bit 1 compliance flag |
| ent_req_o | output | 1 | Level request to the entropy source |
| ent_ack_i | input | 1 | One-cycle acknowledge from the source |
| ent_data_i | input | 32 | Word delivered with the acknowledge |
| ent_fips_i | input | 1 | Compliance flag delivered with the word |

## Verification
The main function is driven with these patterns:
- An acknowledge into an empty register. This separates capture from a missed capture.
- A stray acknowledge while full. This shows whether the held word can be overwritten.
- Reads while full and reads while empty. These separate the consuming read from a read with no effect.
- A read and an acknowledge in the same cycle. This tells whether the arriving word wins.

Words with both flag values show that the flag tracks each word rather than sticking. A reset while full confirms the empty, requesting start state.

// File: rtl/rnd_word_pkg.sv
package rnd_word_pkg;
  typedef enum logic [0:0] {
    ST_FETCH = 1'b0,
    ST_HOLD  = 1'b1
  } rnd_state_e;
endpackage

// File: rtl/rnd_word_fsm.sv
module rnd_word_fsm
  import rnd_word_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic ack_i,
  output logic capture_o,
  output logic consume_o,
  output logic valid_o,
  output logic req_o
);
  rnd_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    capture_o = 1'b0;
    consume_o = 1'b0;
    unique case (state_q)
      ST_FETCH: if (ack_i) begin
        capture_o = 1'b1;
        state_d   = ST_HOLD;
      end
      ST_HOLD: if (rd_i) begin
        consume_o = 1'b1;
        state_d   = ST_FETCH;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign valid_o = (state_q == ST_HOLD);
  assign req_o   = (state_q == ST_FETCH);

  // R2
  fill_on_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> (valid_o && !req_o));
  // R4
  read_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && rd_i) |=> (!valid_o && req_o));
  // R5
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o);
endmodule

// File: rtl/rnd_word_store.sv
module rnd_word_store #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          consume_i,
  input  logic [DW-1:0] data_i,
  input  logic          fips_i,
  output logic [DW-1:0] data_o,
  output logic          fips_o
);
  logic [DW-1:0] data_q, data_d;
  logic          fips_q, fips_d;
  logic          load_en;

  assign load_en = capture_i | consume_i;

  always_comb begin
    data_d = data_q;
    fips_d = fips_q;
    if (capture_i) begin
      data_d = data_i;
      fips_d = fips_i;
    end else if (consume_i) begin
      data_d = '0;
      fips_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      fips_q <= 1'b0;
    end else if (load_en) begin
      data_q <= data_d;
      fips_q <= fips_d;
    end
  end

  assign data_o = data_q;
  assign fips_o = fips_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_i || consume_i) |=> ($stable(data_o) && $stable(fips_o)));
  // R3
  flag_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> (fips_o == $past(fips_i)));
endmodule

// File: rtl/rnd_word_reg.sv
module rnd_word_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    status_o,
  output logic          ent_req_o,
  input  logic          ent_ack_i,
  input  logic [DW-1:0] ent_data_i,
  input  logic          ent_fips_i
);
  logic          capture, consume, valid;
  logic [DW-1:0] word;
  logic          flag;

  rnd_word_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .ack_i     (ent_ack_i),
    .capture_o (capture),
    .consume_o (consume),
    .valid_o   (valid),
    .req_o     (ent_req_o)
  );

  rnd_word_store #(.DW(DW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .consume_i (consume),
    .data_i    (ent_data_i),
    .fips_i    (ent_fips_i),
    .data_o    (word),
    .fips_o    (flag)
  );

  assign rdata_o  = valid ? word : '0;
  assign status_o = {flag & valid, valid};

  // R5
  zero_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[0] |-> (rdata_o == '0));
  // R7
  ack_with_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_req_o && ent_ack_i && rd_i) |=> (status_o[0] && rdata_o == $past(ent_data_i)));
endmodule

// File: tb/rnd_word_reg_test.sv
module rnd_word_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0;
  logic        ent_ack_i = 1'b0;
  logic [31:0] ent_data_i = '0;
  logic        ent_fips_i = 1'b0;
  logic [31:0] rdata_o;
  logic [1:0]  status_o;
  logic        ent_req_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  rnd_word_reg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rdata_o(rdata_o),
    .status_o(status_o), .ent_req_o(ent_req_o), .ent_ack_i(ent_ack_i),
    .ent_data_i(ent_data_i), .ent_fips_i(ent_fips_i)
  );

  // {rd, ack, data, fips, exp_rdata, exp_status, exp_req}; expectations hold before the edge
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         2'b00, 1'b1}, // R1 idle after reset
    {1'b0, 1'b1, 32'hA5A5_0001, 1'b1, 32'h0,         2'b00, 1'b1}, // R2 ack arrives
    {1'b0, 1'b0, 32'h0,         1'b0, 32'hA5A5_0001, 2'b11, 1'b0}, // R3 flag 1 captured
    {1'b0, 1'b1, 32'hDEAD_BEEF, 1'b0, 32'hA5A5_0001, 2'b11, 1'b0}, // R6 stray ack
    {1'b1, 1'b0, 32'h0,         1'b0, 32'hA5A5_0001, 2'b11, 1'b0}, // R6/R4 read sees old word
    {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         2'b00, 1'b1}, // R4 emptied
    {1'b1, 1'b0, 32'h0,         1'b0, 32'h0,         2'b00, 1'b1}, // R5 read while empty
    {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         2'b00, 1'b1}, // R5 still empty
    {1'b1, 1'b1, 32'h1234_5678, 1'b0, 32'h0,         2'b00, 1'b1}, // R7 read with ack
    {1'b0, 1'b0, 32'h0,         1'b0, 32'h1234_5678, 2'b01, 1'b0}, // R7/R3 flag 0
    {1'b1, 1'b0, 32'h0,         1'b0, 32'h1234_5678, 2'b01, 1'b0}, // R4 read
    {1'b0, 1'b0, 32'h0,         1'b0, 32'h0,         2'b00, 1'b1}  // R4 emptied
  };
  localparam int VREQ [NV] = '{1, 2, 3, 6, 6, 4, 5, 5, 7, 7, 4, 4};

  task automatic check(input int rq, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d rdata/status/req actual=%h expected=%h", rq, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R0 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    // R1 reset state
    check(1, {rdata_o, status_o, ent_req_o}, {32'h0, 2'b00, 1'b1});
    @(negedge clk_i) rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      rd_i       = VEC[i][69];
      ent_ack_i  = VEC[i][68];
      ent_data_i = VEC[i][67:36];
      ent_fips_i = VEC[i][35];
      #1;
      check(VREQ[i], {rdata_o, status_o, ent_req_o}, VEC[i][34:0]);
      @(negedge clk_i);
    end
    rd_i = 1'b0;
    ent_ack_i = 1'b0;
    // R2 fill, then reset while full must return to the R1 state
    ent_ack_i = 1'b1; ent_data_i = 32'hCAFE_F00D; ent_fips_i = 1'b1;
    @(negedge clk_i) ent_ack_i = 1'b0;
    #1;
    check(2, {rdata_o, status_o, ent_req_o}, {32'hCAFE_F00D, 2'b11, 1'b0});
    rst_ni = 1'b0;
    #1;
    // R1
    check(1, {rdata_o, status_o, ent_req_o}, {32'h0, 2'b00, 1'b1});
    @(negedge clk_i) rst_ni = 1'b1;
    // R3 flag follows each new word: deliver with flag 0 after one with flag 1
    ent_ack_i = 1'b1; ent_data_i = 32'h0000_0001; ent_fips_i = 1'b0;
    @(negedge clk_i) ent_ack_i = 1'b0;
    #1;
    check(3, {rdata_o, status_o, ent_req_o}, {32'h0000_0001, 2'b01, 1'b0});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule